// File: doc/BRIEF.md
# Configuration Phase Sequencer

This block moves a field-programmable device through its four phases: initialization, configuration, start-up and operating. It watches the active-low board reset and program-request pins, a readiness flag that says the device may start loading, and a strap that selects master or slave loading. While configuration runs, it counts configuration clocks and compares the count with a length value that the loader captures from the bitstream header. Loading is accepted only when both the count matches and the closing frame has arrived.

From its phase the block drives three outputs. The first is a global reset for user flip-flops. The second enables the internal bidirectional buffers. The third is the DONE indication. A 2-bit phase code is brought out so that a bench can observe the sequence. A power-on reset, separate from the board reset pin, initializes the block, because the board reset pin is ignored once loading has finished. Everything runs on the configuration clock.

Top module: `cfg_seq`

## Requirements
- R1: While `por_n` is low, `phase` is 0, `done` is 0, `glob_rst` is 1 and `bidir_oe` is 0.
- R2: In initialization (`phase`=0), the sequencer moves to configuration only on a clock edge at which `rst_n`, `prog_n` and `init_ok` are all 1. In slave mode (`master`=0) it enters configuration on that same edge.
- R3: In master mode (`master`=1), the sequencer needs six further consecutive edges with all three inputs high. Configuration is entered on the seventh such edge.
- R4: In configuration, an edge that sees `rst_n`=0 or `prog_n`=0 returns the sequencer to initialization. This takes priority over completion.
- R5: The internal count is 0 in the first configuration cycle and rises by one per clock. Completion happens on the edge at the end of a cycle in which three things are true: a length has been captured by `len_load` in an earlier cycle, the count equals that length, and `end_frame` was seen in an earlier cycle. A match before capture, or a match that passes without the end frame, does not complete.
- R6: The count is CNT_W bits wide (24 by default) and holds at 2^CNT_W-1 instead of wrapping.
- R7: In initialization and configuration, `glob_rst` is 1 and `bidir_oe` is 0.
- R8: Start-up (`phase`=2) lasts four clocks. `done` is 1 from its first cycle onward. `glob_rst` drops to 0 in its fourth cycle and stays 0 in operating. `bidir_oe` is 1 in start-up and operating.
- R9: In start-up and operating, `rst_n` has no effect. An edge with `prog_n`=0 returns the sequencer to initialization.
- R10: The `phase` output encodes the phases as initialization=0, configuration=1, start-up=2 and operating=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Board reset pin, active low |
| prog_n | input | 1 | Program request pin, active low |
| init_ok | input | 1 | High when the device is ready to load |
| master | input | 1 | 1 selects master loading, 0 selects slave loading |
| len_val | input | CNT_W | Length value from the bitstream header |
| len_load | input | 1 | Captures `len_val` during configuration |
| end_frame | input | 1 | Strobe marking the end-of-configuration frame |
| phase | output | 2 | Current phase code |
| glob_rst | output | 1 | Global set/reset to user flip-flops, active high |
| bidir_oe | output | 1 | Enable for internal bidirectional buffers |
| done | output | 1 | Configuration done indication |

## Verification
Every transition is registered. A phase change caused by an input shows up in the first cycle after the edge that samples that input. Completion appears one cycle after the cycle in which the capture, the count match and the end frame are all in place, and the master extension adds exactly six edges. Inputs change on falling edges. A behavioural model advances on rising edges and is compared with all four outputs at every falling edge. Directed checks are placed at the exact cycle where each boundary is due, such as the last cycle before completion or the sixth extension edge.

// File: rtl/cfg_seq.sv
module cfg_seq #(
  parameter int CNT_W  = 24,
  parameter int EXT_CY = 6,
  parameter int SU_CY  = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             prog_n,
  input  logic             init_ok,
  input  logic             master,
  input  logic [CNT_W-1:0] len_val,
  input  logic             len_load,
  input  logic             end_frame,
  output logic [1:0]       phase,
  output logic             glob_rst,
  output logic             bidir_oe,
  output logic             done
);
  localparam logic [1:0] PH_INIT = 2'd0, PH_CFG = 2'd1, PH_SU = 2'd2, PH_RUN = 2'd3;
  localparam int EXT_W = $clog2(EXT_CY + 1);
  localparam int SU_W  = $clog2(SU_CY);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [EXT_W-1:0] EXT_LAST = EXT_W'(EXT_CY);
  localparam logic [SU_W-1:0]  SU_LAST  = SU_W'(SU_CY - 1);

  logic [1:0]       ph;
  logic [CNT_W-1:0] cnt, len_reg;
  logic             len_vld, end_seen;
  logic [EXT_W-1:0] ext;
  logic [SU_W-1:0]  su;

  wire pins_hi  = rst_n & prog_n;
  wire ready    = pins_hi & init_ok;
  wire ext_done = ~master | (ext == EXT_LAST);
  wire complete = len_vld & end_seen & (cnt == len_reg);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ph       <= PH_INIT;
      cnt      <= '0;
      len_reg  <= '0;
      len_vld  <= 1'b0;
      end_seen <= 1'b0;
      ext      <= '0;
      su       <= '0;
    end else begin
      unique case (ph)
        PH_INIT: begin
          cnt      <= '0;
          len_vld  <= 1'b0;
          end_seen <= 1'b0;
          su       <= '0;
          if (ready && ext_done) begin
            ph  <= PH_CFG;
            ext <= '0;
          end else if (ready) begin
            ext <= ext + 1'b1;
          end else begin
            ext <= '0;
          end
        end
        PH_CFG: begin
          if (!pins_hi) begin
            ph <= PH_INIT;
          end else begin
            if (complete) ph <= PH_SU;
            if (len_load) begin
              len_reg <= len_val;
              len_vld <= 1'b1;
            end
            if (end_frame) end_seen <= 1'b1;
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          end
        end
        PH_SU: begin
          if (!prog_n)           ph <= PH_INIT;
          else if (su == SU_LAST) ph <= PH_RUN;
          else                    su <= su + 1'b1;
        end
        default: begin
          if (!prog_n) ph <= PH_INIT;
        end
      endcase
    end
  end

  assign phase    = ph;
  assign done     = ph[1];
  assign bidir_oe = ph[1];
  assign glob_rst = ~((ph == PH_RUN) | ((ph == PH_SU) & (su == SU_LAST)));
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             prog_n,
  input logic [1:0]       phase,
  input logic             glob_rst,
  input logic             bidir_oe,
  input logic             done,
  input logic             len_vld,
  input logic [CNT_W-1:0] cnt
);
  AST_CFG_HOLDS_RESET: assert property (@(posedge clk) disable iff (!por_n)
    (phase < 2'd2) |-> (glob_rst && !bidir_oe && !done)); // R7
  AST_ABORT_IN_CFG: assert property (@(posedge clk) disable iff (!por_n)
    (phase == 2'd1 && (!rst_n || !prog_n)) |=> (phase == 2'd0)); // R4
  AST_INIT_GATED: assert property (@(posedge clk) disable iff (!por_n)
    (phase == 2'd0 && !(rst_n && prog_n)) |=> (phase == 2'd0)); // R2
  AST_RESET_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
    (phase[1] && prog_n) |=> (phase[1])); // R9
  AST_PROG_RECONFIG: assert property (@(posedge clk) disable iff (!por_n)
    (phase[1] && !prog_n) |=> (phase == 2'd0)); // R9
  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!por_n)
    (phase == 2'd1 && !len_vld) |=> (phase != 2'd2)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!por_n)
    (phase == 2'd1 && cnt == {CNT_W{1'b1}}) |=> (phase != 2'd1 || cnt == {CNT_W{1'b1}})); // R6
  AST_DONE_LATE: assert property (@(posedge clk) disable iff (!por_n)
    phase[1] |-> (done && bidir_oe)); // R8
endmodule

bind cfg_seq cfg_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .prog_n(prog_n), .phase(phase),
  .glob_rst(glob_rst), .bidir_oe(bidir_oe), .done(done), .len_vld(len_vld), .cnt(cnt)
);

// File: tb/cfg_seq_bench.sv
`timescale 1ns/1ps
module cfg_seq_bench;
  localparam int CW = 6;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b1, prog_n = 1'b1, init_ok = 1'b0, master = 1'b0;
  logic [CW-1:0] len_val = '0;
  logic len_load = 1'b0, end_frame = 1'b0;
  logic [1:0] phase;
  logic glob_rst, bidir_oe, done;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  cfg_seq #(.CNT_W(CW)) u_cfg_seq (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .prog_n(prog_n), .init_ok(init_ok),
    .master(master), .len_val(len_val), .len_load(len_load), .end_frame(end_frame),
    .phase(phase), .glob_rst(glob_rst), .bidir_oe(bidir_oe), .done(done)
  );

  int m_ph, m_cnt, m_len, m_ext, m_su;
  bit m_lv, m_end;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_ph = 0; m_cnt = 0; m_len = 0; m_ext = 0; m_su = 0; m_lv = 0; m_end = 0;
    end else if (m_ph == 0) begin
      m_cnt = 0; m_lv = 0; m_end = 0; m_su = 0;
      if (rst_n && prog_n && init_ok) begin
        if (!master || m_ext == 6) begin m_ph = 1; m_ext = 0; end
        else m_ext = m_ext + 1;
      end else m_ext = 0;
    end else if (m_ph == 1) begin
      if (!rst_n || !prog_n) m_ph = 0;
      else begin
        if (m_lv && m_end && m_cnt == m_len) m_ph = 2;
        if (len_load) begin m_len = int'(len_val); m_lv = 1; end
        if (end_frame) m_end = 1;
        if (m_cnt < MAXC) m_cnt = m_cnt + 1;
      end
    end else if (m_ph == 2) begin
      if (!prog_n) m_ph = 0;
      else if (m_su == 3) m_ph = 3;
      else m_su = m_su + 1;
    end else begin
      if (!prog_n) m_ph = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R10 phase vs model", int'(phase), m_ph);
    chk("R8 done vs model", int'(done), int'(m_ph >= 2));
    chk("R7 bidir_oe vs model", int'(bidir_oe), int'(m_ph >= 2));
    chk("R7 glob_rst vs model", int'(glob_rst), int'(!(m_ph == 3 || (m_ph == 2 && m_su == 3))));
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_load(input int v);
    len_val = CW'(v); len_load = 1'b1; step(1); len_load = 1'b0;
  endtask

  task automatic pulse_end();
    end_frame = 1'b1; step(1); end_frame = 1'b0;
  endtask

  task automatic run();
    step(2);
    chk("R1 phase in por", int'(phase), 0);
    chk("R1 done in por", int'(done), 0);
    chk("R1 glob_rst in por", int'(glob_rst), 1);
    chk("R1 bidir_oe in por", int'(bidir_oe), 0);
    por_n = 1'b1; rst_n = 1'b0; init_ok = 1'b1;
    step(3);
    chk("R2 held by rst_n", int'(phase), 0);
    rst_n = 1'b1; step(1);
    chk("R2 slave enters cfg", int'(phase), 1);
    pulse_load(10);
    pulse_end();
    step(8);
    chk("R5 cycle before match", int'(phase), 1);
    chk("R7 glob_rst in cfg", int'(glob_rst), 1);
    step(1);
    chk("R5 completes", int'(phase), 2);
    chk("R8 done first su cycle", int'(done), 1);
    chk("R8 glob_rst held early su", int'(glob_rst), 1);
    step(3);
    chk("R8 glob_rst released", int'(glob_rst), 0);
    chk("R8 still su", int'(phase), 2);
    step(1);
    chk("R8 operating", int'(phase), 3);
    rst_n = 1'b0; step(3);
    chk("R9 rst_n ignored", int'(phase), 3);
    rst_n = 1'b1; prog_n = 1'b0; step(1);
    chk("R9 prog returns init", int'(phase), 0);
    chk("R7 glob_rst in init", int'(glob_rst), 1);
    master = 1'b1; prog_n = 1'b1; step(6);
    chk("R3 master extension", int'(phase), 0);
    step(1);
    chk("R3 master enters cfg", int'(phase), 1);
    master = 1'b0;
    pulse_end();
    step(20);
    chk("R5 no capture no done", int'(phase), 1);
    prog_n = 1'b0; step(1);
    chk("R4 prog abort", int'(phase), 0);
    prog_n = 1'b1; step(1);
    chk("R2 re-enter cfg", int'(phase), 1);
    pulse_load(5);
    step(19);
    pulse_end();
    step(5);
    chk("R5 match passed", int'(phase), 1);
    rst_n = 1'b0; step(1);
    chk("R4 rst abort", int'(phase), 0);
    rst_n = 1'b1; step(1);
    chk("R2 enter cfg again", int'(phase), 1);
    pulse_load(MAXC);
    step(99);
    pulse_end();
    chk("R6 not yet", int'(phase), 1);
    step(1);
    chk("R6 saturated match", int'(phase), 2);
    step(4);
    chk("R8 operating after sat", int'(phase), 3);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule